// File: doc/BRIEF.md
# Cell Delineation and Header Guard

This block finds where cells begin on each of several serial links. It then protects the switch from cells whose headers are damaged. Upstream logic turns every link into a stream of assembled cells. The cells of all links share one cell-wide path, one cell per clock, and each cell carries the number of its link. For every link the block keeps its own state.

While a link is not aligned, the block assumes that the current bit position is the cell boundary and tests the header check byte. When the test fails, it asks the upstream shifter to move that link by one bit position. After a run of consecutive good headers the link is declared aligned, and its boundary is then held fixed.

On an aligned link only header integrity is checked. A cell with a damaged header is replaced by an idle cell. A long run of damaged headers marks the link as failed, and the search starts again. Cells from links that are not aligned also leave as idle cells, so nothing unverified reaches routing.

Top module: `cell_delin`

## Requirements
- R1: After reset every link is unaligned (`lock` all zero), and `out_vld` and `slip_req` are low until a cell is offered.
- R2: A header is good only when its low byte `hdr[7:0]` equals the CRC-8 of `hdr[39:8]` XOR 0x55. The CRC uses polynomial x^8+x^2+x+1 and a zero start value, and `hdr[39:32]` is sent first, most significant bit first. Flipping any single one of the 40 bits makes the header bad.
- R3: On a link that is searching, a bad header raises `slip_req` for exactly one cycle, one clock after the cell, with `slip_link` naming that link. Any partial run of good headers is discarded.
- R4: The next cell of a link that has just slipped is not tested. It never raises `slip_req` and never counts toward alignment.
- R5: Six consecutive good headers on a searching link set that link's `lock` bit one clock after the sixth cell.
- R6: Every offered cell leaves one clock later, with `out_vld` high and `out_link` equal to its link. On an aligned link a cell with a good header leaves with its header and payload unchanged.
- R7: On an aligned link a cell with a bad header leaves as the idle cell. The idle header is 00 00 00 01 followed by check byte 0x52, and the idle payload is every byte 0x6A.
- R8: Seven consecutive bad headers on an aligned link clear its `lock` bit one clock after the seventh cell. No slip is requested at that moment, and one good header restarts the count.
- R9: Cells from links that are not aligned leave as idle cells.
- R10: `slip_req` is never raised for a link that was aligned when its cell arrived.
- R11: A cell changes the state of its own link only. At most one `lock` bit changes per clock, and only when a cell was offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | A cell is offered this clock |
| in_link | input | LINK_W | Link the offered cell came from |
| in_hdr | input | 40 | Header, check byte in bits 7:0 |
| in_pay | input | PAY_W | Cell payload |
| out_vld | output | 1 | A cell leaves this clock |
| out_link | output | LINK_W | Link of the leaving cell |
| out_hdr | output | 40 | Header after idle substitution |
| out_pay | output | PAY_W | Payload after idle substitution |
| slip_req | output | 1 | Request to shift one link by one bit position |
| slip_link | output | LINK_W | Link that must shift |
| lock | output | N_LINKS | Per-link alignment status |

## Verification
Every cell result (`out_vld`, `out_link`, `out_hdr`, `out_pay`, `slip_req`, `slip_link`) is due exactly one clock after the cell is presented, because the only register on that path is the output stage. The `lock` bit of a link moves at the same edge. The bench drives a cell on the falling edge, updates its own per-link model at once, and compares all outputs on the next falling edge, before it drives the following cell. In this way each comparison sees the result of precisely one cell.

// File: rtl/cell_delin_pkg.sv
package cell_delin_pkg;

   localparam int          HDR_W     = 40;
   localparam logic [7:0]  HEC_POLY  = 8'h07;
   localparam logic [7:0]  HEC_COSET = 8'h55;

   typedef enum logic [1:0] {
      LM_HUNT = 2'd0,
      LM_WAIT = 2'd1,
      LM_LOCK = 2'd2
   } link_mode_e;

   // serial CRC-8, first byte in the top bits, zero start value
   function automatic logic [7:0] crc8_word(input logic [31:0] d);
      logic [7:0] c;
      logic       fb;
      c = 8'h00;
      for (int i = 31; i >= 0; i--) begin
         fb = c[7] ^ d[i];
         c  = {c[6:0], 1'b0};
         if (fb) c = c ^ HEC_POLY;
      end
      return c;
   endfunction

   function automatic logic [7:0] hec_byte(input logic [31:0] d, input bit coset_en);
      return coset_en ? (crc8_word(d) ^ HEC_COSET) : crc8_word(d);
   endfunction

   function automatic logic [HDR_W-1:0] idle_header(input bit coset_en);
      return {32'h0000_0001, hec_byte(32'h0000_0001, coset_en)};
   endfunction

endpackage

// File: rtl/cdh_hec_chk.sv
module cdh_hec_chk
   import cell_delin_pkg::*;
#(
   parameter bit COSET_EN = 1'b1
) (
   input  logic [HDR_W-1:0] hdr,
   output logic             hdr_ok
);

   logic [7:0] crc_raw;
   logic [7:0] crc_exp;

   assign crc_raw = crc8_word(hdr[HDR_W-1:8]);

   generate
      if (COSET_EN) begin : g_coset
         assign crc_exp = crc_raw ^ HEC_COSET;
      end else begin : g_plain
         assign crc_exp = crc_raw;
      end
   endgenerate

   assign hdr_ok = (crc_exp == hdr[7:0]);

endmodule

// File: rtl/cdh_link_fsm.sv
module cdh_link_fsm
   import cell_delin_pkg::*;
#(
   parameter int LOCK_GOOD  = 6,
   parameter int UNLOCK_BAD = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic hdr_ok,
   output logic locked,
   output logic slip,
   output logic pass
);

   localparam int CNT_TOP = (LOCK_GOOD > UNLOCK_BAD) ? LOCK_GOOD : UNLOCK_BAD;
   localparam int CNT_W   = (CNT_TOP < 2) ? 1 : $clog2(CNT_TOP);
   localparam logic [CNT_W-1:0] GOOD_LAST = CNT_W'(LOCK_GOOD - 1);
   localparam logic [CNT_W-1:0] BAD_LAST  = CNT_W'(UNLOCK_BAD - 1);

   link_mode_e       mode_q, mode_d;
   logic [CNT_W-1:0] run_q, run_d;

   always_comb begin
      mode_d = mode_q;
      run_d  = run_q;
      slip   = 1'b0;
      pass   = 1'b0;
      if (hit) begin
         unique case (mode_q)
            LM_HUNT: begin
               if (hdr_ok) begin
                  if (run_q == GOOD_LAST) begin
                     mode_d = LM_LOCK;
                     run_d  = '0;
                  end else begin
                     run_d  = run_q + 1'b1;
                  end
               end else begin
                  slip   = 1'b1;
                  mode_d = LM_WAIT;
                  run_d  = '0;
               end
            end
            LM_WAIT: begin
               mode_d = LM_HUNT;
               run_d  = '0;
            end
            LM_LOCK: begin
               if (hdr_ok) begin
                  pass  = 1'b1;
                  run_d = '0;
               end else if (run_q == BAD_LAST) begin
                  mode_d = LM_HUNT;
                  run_d  = '0;
               end else begin
                  run_d  = run_q + 1'b1;
               end
            end
            default: begin
               mode_d = LM_HUNT;
               run_d  = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= LM_HUNT;
         run_q  <= '0;
      end else begin
         mode_q <= mode_d;
         run_q  <= run_d;
      end
   end

   assign locked = (mode_q == LM_LOCK);

endmodule

// File: rtl/cdh_out_stage.sv
module cdh_out_stage
   import cell_delin_pkg::*;
#(
   parameter int         LINK_W    = 3,
   parameter int         PAY_W     = 384,
   parameter logic [7:0] FILL_BYTE = 8'h6A,
   parameter bit         COSET_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [LINK_W-1:0] in_link,
   input  logic [HDR_W-1:0]  in_hdr,
   input  logic [PAY_W-1:0]  in_pay,
   input  logic              pass,
   input  logic              slip,
   output logic              out_vld,
   output logic [LINK_W-1:0] out_link,
   output logic [HDR_W-1:0]  out_hdr,
   output logic [PAY_W-1:0]  out_pay,
   output logic              slip_req,
   output logic [LINK_W-1:0] slip_link
);

   localparam logic [HDR_W-1:0] IDLE_HDR   = idle_header(COSET_EN);
   localparam int               FILL_BYTES = PAY_W / 8;
   localparam int               FILL_REST  = PAY_W % 8;

   logic [PAY_W-1:0] idle_pay;

   generate
      for (genvar b = 0; b < FILL_BYTES; b++) begin : g_fill
         assign idle_pay[b*8 +: 8] = FILL_BYTE;
      end
      if (FILL_REST != 0) begin : g_rest
         assign idle_pay[PAY_W-1 -: FILL_REST] = FILL_BYTE[FILL_REST-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld   <= 1'b0;
         out_link  <= '0;
         out_hdr   <= '0;
         out_pay   <= '0;
         slip_req  <= 1'b0;
         slip_link <= '0;
      end else begin
         out_vld   <= in_vld;
         out_link  <= in_link;
         out_hdr   <= pass ? in_hdr : IDLE_HDR;
         out_pay   <= pass ? in_pay : idle_pay;
         slip_req  <= in_vld & slip;
         slip_link <= in_link;
      end
   end

endmodule

// File: rtl/cell_delin.sv
module cell_delin
   import cell_delin_pkg::*;
#(
   parameter int         N_LINKS    = 8,
   parameter int         PAY_W      = 384,
   parameter int         LOCK_GOOD  = 6,
   parameter int         UNLOCK_BAD = 7,
   parameter logic [7:0] FILL_BYTE  = 8'h6A,
   parameter bit         COSET_EN   = 1'b1,
   localparam int        LINK_W     = (N_LINKS < 2) ? 1 : $clog2(N_LINKS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_vld,
   input  logic [LINK_W-1:0]  in_link,
   input  logic [HDR_W-1:0]   in_hdr,
   input  logic [PAY_W-1:0]   in_pay,
   output logic               out_vld,
   output logic [LINK_W-1:0]  out_link,
   output logic [HDR_W-1:0]   out_hdr,
   output logic [PAY_W-1:0]   out_pay,
   output logic               slip_req,
   output logic [LINK_W-1:0]  slip_link,
   output logic [N_LINKS-1:0] lock
);

   generate
      if (N_LINKS < 2)    begin : g_bad_links $error("N_LINKS must be at least 2"); end
      if (LOCK_GOOD < 1)  begin : g_bad_good  $error("LOCK_GOOD must be at least 1"); end
      if (UNLOCK_BAD < 1) begin : g_bad_bad   $error("UNLOCK_BAD must be at least 1"); end
      if (PAY_W < 8)      begin : g_bad_pay   $error("PAY_W must be at least 8"); end
   endgenerate

   logic               hdr_ok;
   logic [N_LINKS-1:0] slip_vec;
   logic [N_LINKS-1:0] pass_vec;

   cdh_hec_chk #(.COSET_EN(COSET_EN)) u_hec (
      .hdr    (in_hdr),
      .hdr_ok (hdr_ok)
   );

   generate
      for (genvar g = 0; g < N_LINKS; g++) begin : g_link
         logic hit;
         assign hit = in_vld && (in_link == LINK_W'(g));
         cdh_link_fsm #(
            .LOCK_GOOD  (LOCK_GOOD),
            .UNLOCK_BAD (UNLOCK_BAD)
         ) u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (hit),
            .hdr_ok (hdr_ok),
            .locked (lock[g]),
            .slip   (slip_vec[g]),
            .pass   (pass_vec[g])
         );
      end
   endgenerate

   cdh_out_stage #(
      .LINK_W    (LINK_W),
      .PAY_W     (PAY_W),
      .FILL_BYTE (FILL_BYTE),
      .COSET_EN  (COSET_EN)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (in_vld),
      .in_link   (in_link),
      .in_hdr    (in_hdr),
      .in_pay    (in_pay),
      .pass      (|pass_vec),
      .slip      (|slip_vec),
      .out_vld   (out_vld),
      .out_link  (out_link),
      .out_hdr   (out_hdr),
      .out_pay   (out_pay),
      .slip_req  (slip_req),
      .slip_link (slip_link)
   );

endmodule

// File: rtl/cell_delin_chk.sv
module cell_delin_chk
   import cell_delin_pkg::*;
#(
   parameter int N_LINKS  = 8,
   parameter int LINK_W   = 3,
   parameter bit COSET_EN = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_vld,
   input logic               out_vld,
   input logic [LINK_W-1:0]  out_link,
   input logic [HDR_W-1:0]   out_hdr,
   input logic               slip_req,
   input logic [LINK_W-1:0]  slip_link,
   input logic [N_LINKS-1:0] lock
);

   logic [N_LINKS-1:0] lock_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lock_q <= '0;
      else        lock_q <= lock;
   end

   // R6
   cell_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);

   // R1
   no_ghost_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);

   // R2
   hdr_sound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_hdr[7:0] == hec_byte(out_hdr[HDR_W-1:8], COSET_EN)));

   // R3
   slip_tied_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slip_req |-> (out_vld && out_link == slip_link && out_hdr == idle_header(COSET_EN)));

   // R10
   slip_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slip_req |-> !lock_q[slip_link]);

   // R11
   one_lock_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lock ^ lock_q) <= 1);

   // R11
   lock_needs_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock != lock_q) |-> out_vld);

   // R5
   lock_own_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock != lock_q) |-> (lock[out_link] != lock_q[out_link]));

endmodule

bind cell_delin cell_delin_chk #(
   .N_LINKS  (N_LINKS),
   .LINK_W   (LINK_W),
   .COSET_EN (COSET_EN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_vld    (in_vld),
   .out_vld   (out_vld),
   .out_link  (out_link),
   .out_hdr   (out_hdr),
   .slip_req  (slip_req),
   .slip_link (slip_link),
   .lock      (lock)
);

// File: tb/sim_cell_delin.sv
module sim_cell_delin;

   localparam int NL     = 8;
   localparam int LW     = 3;
   localparam int PW     = 384;
   localparam int HW     = 40;
   localparam int M_HUNT = 0;
   localparam int M_WAIT = 1;
   localparam int M_LOCK = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_vld = 1'b0;
   logic [LW-1:0] in_link = '0;
   logic [HW-1:0] in_hdr = '0;
   logic [PW-1:0] in_pay = '0;
   logic          out_vld;
   logic [LW-1:0] out_link;
   logic [HW-1:0] out_hdr;
   logic [PW-1:0] out_pay;
   logic          slip_req;
   logic [LW-1:0] slip_link;
   logic [NL-1:0] lock;

   int checks = 0;
   int errors = 0;
   int mode [NL];
   int run  [NL];

   always #4 clk = ~clk;

   cell_delin u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_link(in_link),
      .in_hdr(in_hdr), .in_pay(in_pay), .out_vld(out_vld), .out_link(out_link),
      .out_hdr(out_hdr), .out_pay(out_pay), .slip_req(slip_req),
      .slip_link(slip_link), .lock(lock)
   );

   // byte-wise CRC-8, polynomial 0x07, then coset 0x55
   function automatic logic [7:0] ref_hec(input logic [31:0] d);
      logic [7:0] c = 8'h00;
      for (int k = 3; k >= 0; k--) begin
         c = c ^ d[k*8 +: 8];
         for (int s = 0; s < 8; s++)
            c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c ^ 8'h55;
   endfunction

   function automatic logic [HW-1:0] idle_hdr();
      return {32'h0000_0001, 8'h52};
   endfunction

   function automatic logic [PW-1:0] idle_pay();
      logic [PW-1:0] p;
      for (int k = 0; k < PW/8; k++) p[k*8 +: 8] = 8'h6A;
      return p;
   endfunction

   function automatic logic [HW-1:0] good_hdr(input logic [31:0] d);
      return {d, ref_hec(d)};
   endfunction

   function automatic logic [PW-1:0] rand_pay();
      logic [PW-1:0] p;
      for (int k = 0; k < PW/32; k++) p[k*32 +: 32] = $urandom;
      return p;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [PW-1:0] act, input logic [PW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // drive one cell on a falling edge, compare its result on the next one
   task automatic send(input int l, input bit v, input logic [HW-1:0] h, input string htag);
      bit            good;
      bit            e_slip = 1'b0;
      bit            e_pass = 1'b0;
      string         t_slip = "R3";
      string         t_hdr  = "R9";
      string         t_lock = "R11";
      logic [NL-1:0] e_lock;
      logic [PW-1:0] pay;
      pay      = rand_pay();
      in_vld   = v;
      in_link  = LW'(l);
      in_hdr   = h;
      in_pay   = pay;
      good     = (h[7:0] == ref_hec(h[HW-1:8]));
      if (v) begin
         case (mode[l])
            M_HUNT: begin
               t_slip = "R3";
               if (good) begin
                  run[l]++;
                  if (run[l] == 6) begin mode[l] = M_LOCK; run[l] = 0; t_lock = "R5"; end
               end else begin
                  e_slip = 1'b1; mode[l] = M_WAIT; run[l] = 0;
               end
            end
            M_WAIT: begin
               t_slip = "R4"; t_lock = "R4"; mode[l] = M_HUNT; run[l] = 0;
            end
            default: begin
               t_slip = "R10";
               if (good) begin
                  e_pass = 1'b1; t_hdr = "R6"; run[l] = 0;
               end else begin
                  t_hdr = "R7"; run[l]++;
                  if (run[l] == 7) begin mode[l] = M_HUNT; run[l] = 0; t_lock = "R8"; end
               end
            end
         endcase
      end
      if (htag != "") t_hdr = htag;
      for (int k = 0; k < NL; k++) e_lock[k] = (mode[k] == M_LOCK);
      @(negedge clk);
      check(out_vld == v, "R6", "out_vld", PW'(out_vld), PW'(v));
      check(slip_req == e_slip, t_slip, "slip_req", PW'(slip_req), PW'(e_slip));
      check(lock == e_lock, t_lock, "lock", PW'(lock), PW'(e_lock));
      if (v) begin
         check(out_link == LW'(l), "R6", "out_link", PW'(out_link), PW'(l));
         if (e_slip)
            check(slip_link == LW'(l), "R3", "slip_link", PW'(slip_link), PW'(l));
         check(out_hdr == (e_pass ? h : idle_hdr()), t_hdr, "out_hdr",
               PW'(out_hdr), PW'(e_pass ? h : idle_hdr()));
         check(out_pay == (e_pass ? pay : idle_pay()), t_hdr, "out_pay",
               out_pay, e_pass ? pay : idle_pay());
      end
   endtask

   task automatic send_good(input int l);
      send(l, 1'b1, good_hdr($urandom), "");
   endtask

   task automatic send_bad(input int l);
      logic [HW-1:0] h;
      h = good_hdr($urandom);
      h[$urandom % HW] ^= 1'b1;
      send(l, 1'b1, h, "");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R6 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [HW-1:0] h;
      void'($urandom(32'd7741));
      for (int k = 0; k < NL; k++) begin mode[k] = M_HUNT; run[k] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(lock == '0, "R1", "lock", PW'(lock), '0);
      check(!out_vld, "R1", "out_vld", PW'(out_vld), '0);
      check(!slip_req, "R1", "slip_req", PW'(slip_req), '0);

      // R3 slip, R4 skipped cell, R5 lock, R6 pass, R7 idle replacement
      send_bad(0);
      send_bad(0);
      for (int k = 0; k < 5; k++) send_good(0);
      send_bad(0);
      send_bad(0);
      for (int k = 0; k < 6; k++) send_good(0);
      send_good(0);
      send_bad(0);
      send_good(0);

      // R11 interleaved links
      for (int k = 0; k < 6; k++) begin send_good(3); send_bad(5); end
      send(3, 1'b0, '0, "");

      // R2 every single-bit error on a locked link
      for (int b = 0; b < HW; b++) begin
         h = good_hdr($urandom);
         h[b] ^= 1'b1;
         send(3, 1'b1, h, "R2");
         send_good(3);
      end

      // R8 six bad then a good restart the count, seven bad unlock
      for (int k = 0; k < 6; k++) send_bad(0);
      send_good(0);
      for (int k = 0; k < 7; k++) send_bad(0);
      send_bad(0);
      send_good(0);

      // random traffic, first mostly clean then noisy
      for (int n = 0; n < 4000; n++) begin
         int  l;
         bit  v;
         int  pct;
         l   = $urandom % NL;
         v   = ($urandom % 10) != 0;
         pct = (n < 2000) ? 92 : 45;
         if (($urandom % 100) < pct) send(l, v, good_hdr($urandom), "");
         else begin
            h = good_hdr($urandom);
            h[$urandom % HW] ^= 1'b1;
            send(l, v, h, "");
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule